// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Character Buffer

This block receives asynchronous serial characters on a single input line. The line is sampled on a 16x oversampling tick that comes from outside the block. A frame holds 5 to 9 data bits, with an optional even or odd parity bit and one stop bit. Each finished character goes into a small first-in first-out buffer, together with its ninth bit and its own error flags. A processor-side register port reads that buffer.

The character at the head of the buffer shows its ninth bit and its error flags in a status register. Reading the data register returns the low eight bits and removes the head character. Software therefore reads the status register, including the ninth bit, before it reads the data byte. An interrupt line reports that characters are waiting. Turning the receiver off throws away everything it holds.

Register map (addr): 0 = data (read only, a read pops the buffer); 1 = status (read only); 2 = control; 3 = frame format. Writes to addresses 0 and 1 have no effect.

Top module: `uart_rx_buf`

## Requirements
- R1: `irq` is 1 only when all three conditions hold: control bit 0 (interrupt enable) is 1, the `gie` input is 1, and status bit 0 (receive complete) is 1.
- R2: When control bit 1 (receiver enable) is 0, the buffer is emptied within one clock. All status bits then read 0, and they stay 0 after the receiver is enabled again.
- R3: `rx_owned` equals control bit 1, so the serial pin belongs to the receiver only while the receiver is enabled.
- R4: The data bit count comes from the size code {control bit 2, format bits 1:0}. The codes are 000=5, 001=6, 010=7, 011=8 and 111=9, and any other code gives 8. Data bits arrive LSB first and unused upper data bits read as 0.
- R5: Status bit 4 holds bit 8 of the head character. A read of address 0 returns bits 7:0 of the head character and removes it.
- R6: After reset, control reads 0x00, format reads 0x03 (8 data bits, no parity), status reads 0x00, and `irq` and `rx_owned` are 0.
- R7: The buffer holds DEPTH (2) characters. If a character completes while the buffer is full and nothing is read in the same clock, that character is lost and status bit 2 (overrun) is set on the head character.
- R8: Status bit 0 (receive complete) is 1 exactly while the buffer holds at least one character. It clears after the last character has been read.
- R9: A start bit is accepted only when the majority of oversampling samples 7, 8 and 9 is low. A shorter low pulse returns the receiver to idle, and no character is stored.
- R10: Status bit 1 (frame error) of a character is 1 when its stop bit sampled low.
- R11: Format bits 3:2 select the parity mode: 0x = none, 10 = even, 11 = odd. Status bit 3 (parity error) is set when the received parity bit does not match the selected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_pin | input | 1 | Serial receive line, idle high |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the buffer at address 0) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Receive-complete interrupt |
| rx_owned | output | 1 | Receiver has taken over the serial pin |

## Verification
The hardest state to reach from the ports is a character arriving while the buffer is already full. A second hard state is the moment the receiver is disabled while characters and their error flags are still buffered. The stimulus reaches both by sending back-to-back frames without reading in between: three frames for the overrun case, and two frames, one with a low stop bit, for the flush case. The bench then checks which characters survive and which flags they carry. A low pulse shorter than the majority window exercises start rejection. Random frames then vary the size code, the parity mode, forced parity errors and forced stop errors.

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_pin,
  input  logic       gie,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       rx_owned
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 12;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0] sync;
  logic ie, en, sz2;
  logic [1:0] szl, pmode;
  st_t st;
  logic [3:0] tc, bi, nbits;
  logic [1:0] vote;
  logic [8:0] sh;
  logic pbit;
  logic [EW-1:0] buf_q [DEPTH];
  logic [CW-1:0] cnt;
  logic [EW-1:0] head, ent;
  logic [IW-1:0] wi;
  logic rx_s, bitv, at_mid, push, pop, full, rxc, acc;

  assign rx_s   = sync[1];
  assign bitv   = (vote[1] & vote[0]) | (vote[1] & rx_s) | (vote[0] & rx_s);
  assign at_mid = tick16 && tc == 4'd9;
  assign push   = en && st == S_STOP && at_mid;
  assign pop    = rd_en && addr == 2'd0 && cnt != '0;
  assign full   = cnt == CW'(DEPTH);
  assign rxc    = cnt != '0;
  assign head   = buf_q[0];
  assign ent    = {~bitv, pmode[1] & (^sh ^ pbit ^ pmode[0]), 1'b0, sh};
  assign wi     = IW'(pop ? cnt - 1'b1 : cnt);
  assign acc    = push && (pop || !full);
  assign irq    = ie & gie & rxc;
  assign rx_owned = en;

  always_comb begin
    case ({sz2, szl})
      3'b000:  nbits = 4'd5;
      3'b001:  nbits = 4'd6;
      3'b010:  nbits = 4'd7;
      3'b111:  nbits = 4'd9;
      default: nbits = 4'd8;
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = head[7:0];
      2'd1:    rdata = {3'b000, head[8], head[10], head[9], head[11], rxc};
      2'd2:    rdata = {5'b00000, sz2, en, ie};
      default: rdata = {4'b0000, pmode, szl};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; en <= 1'b0; sz2 <= 1'b0; szl <= 2'b11; pmode <= 2'b00;
    end else if (wr_en) begin
      if (addr == 2'd2) begin ie <= wdata[0]; en <= wdata[1]; sz2 <= wdata[2]; end
      if (addr == 2'd3) begin szl <= wdata[1:0]; pmode <= wdata[3:2]; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; st <= S_IDLE; tc <= '0; bi <= '0; vote <= 2'b11; sh <= '0; pbit <= 1'b0;
    end else begin
      sync <= {sync[0], rx_pin};
      if (!en) begin
        st <= S_IDLE; tc <= '0;
      end else if (tick16) begin
        tc <= tc + 4'd1;
        if (tc == 4'd7 || tc == 4'd8) vote <= {vote[0], rx_s};
        case (st)
          S_IDLE: begin
            tc <= '0;
            if (!rx_s) begin st <= S_START; sh <= '0; bi <= '0; end
          end
          S_START:
            if (tc == 4'd9 && bitv) st <= S_IDLE;
            else if (tc == 4'd15) st <= S_DATA;
          S_DATA: begin
            if (tc == 4'd9) sh[bi] <= bitv;
            if (tc == 4'd15) begin
              if (bi == nbits - 4'd1) st <= pmode[1] ? S_PAR : S_STOP;
              else bi <= bi + 4'd1;
            end
          end
          S_PAR: begin
            if (tc == 4'd9) pbit <= bitv;
            if (tc == 4'd15) st <= S_STOP;
          end
          default: if (tc == 4'd9) st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else if (!en) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (pop)
        for (int i = 0; i < DEPTH; i++)
          buf_q[i] <= (i == DEPTH - 1) ? '0 : buf_q[(i + 1) % DEPTH];
      if (acc) buf_q[wi] <= ent;
      else if (push) buf_q[0][9] <= 1'b1;
      cnt <= cnt + CW'(acc) - CW'(pop);
    end
  end

  p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n) !en |=> cnt == '0);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  p_overrun_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> head[9]);
  p_empty_after_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == CW'(1) && !push) |=> !rxc && !irq);
  p_irq_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ie && gie && cnt != '0);
endmodule

// File: tb/uart_rx_buf_bench.sv
module uart_rx_buf_bench;
  logic clk = 0, rst_n = 0, tick16 = 0, rx_pin = 1, gie = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, rx_owned;
  int total = 0, fails = 0, cyc = 0;
  logic [1:0] tdiv = 0;

  uart_rx_buf u_uart_rx_buf (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
    .gie(gie), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rx_owned(rx_owned));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [2:0] szcode(input int nb);
    case (nb)
      5: return 3'b000;
      6: return 3'b001;
      7: return 3'b010;
      9: return 3'b111;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [7:0] stat(input logic c, fe, ov, pe, n9);
    return {3'b000, n9, pe, ov, fe, c};
  endfunction

  function automatic logic [8:0] mask(input logic [8:0] d, input int nb);
    return d & ((9'd1 << nb) - 9'd1);
  endfunction

  task automatic bitout(input logic v, input int n);
    rx_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic [1:0] pm,
                      input logic badp, input logic bads);
    logic [8:0] m;
    m = mask(d, nb);
    @(negedge clk);
    bitout(0, 64);
    for (int i = 0; i < nb; i++) bitout(m[i], 64);
    if (pm[1]) bitout((^m) ^ pm[0] ^ badp, 64);
    if (bads) begin bitout(0, 48); bitout(1, 16); end
    else bitout(1, 64);
    bitout(1, 32);
  endtask

  task automatic cfg(input int nb, input logic [1:0] pm, input logic ie);
    logic [2:0] c;
    c = szcode(nb);
    wr(2'd3, {4'b0000, pm, c[1:0]});
    wr(2'd2, {5'b00000, c[2], 1'b1, ie});
  endtask

  logic [7:0] r;

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd2, r); chk("R6 ctrl", r, 8'h00);
    rd(2'd3, r); chk("R6 fmt", r, 8'h03);
    rd(2'd1, r); chk("R6 status", r, 8'h00);
    chk("R6 irq", irq, 0);
    chk("R3 owned off", rx_owned, 0);

    wr(2'd2, 8'h02);
    chk("R3 owned on", rx_owned, 1);

    send(9'h0A5, 8, 2'b00, 0, 0);
    rd(2'd1, r); chk("R8 rxc set", r, stat(1, 0, 0, 0, 0));
    chk("R1 irq ie=0", irq, 0);
    wr(2'd2, 8'h03); gie = 0; #1;
    chk("R1 irq gie=0", irq, 0);
    gie = 1; #1;
    chk("R1 irq all", irq, 1);
    rd(2'd0, r); chk("R4 8-bit data", r, 8'hA5);
    rd(2'd1, r); chk("R8 rxc clear", r, 8'h00);
    chk("R1 irq empty", irq, 0);

    cfg(9, 2'b00, 0);
    send(9'h1C3, 9, 2'b00, 0, 0);
    rd(2'd1, r); chk("R5 ninth bit", r, stat(1, 0, 0, 0, 1));
    rd(2'd0, r); chk("R5 low byte", r, 8'hC3);
    rd(2'd1, r); chk("R5 popped", r, 8'h00);

    cfg(5, 2'b00, 0);
    send(9'h1FF, 5, 2'b00, 0, 0);
    rd(2'd0, r); chk("R4 5-bit data", r, 8'h1F);

    cfg(8, 2'b00, 0);
    send(9'h011, 8, 2'b00, 0, 0);
    send(9'h022, 8, 2'b00, 0, 0);
    send(9'h033, 8, 2'b00, 0, 0);
    rd(2'd1, r); chk("R7 overrun flag", r, stat(1, 0, 1, 0, 0));
    rd(2'd0, r); chk("R7 first kept", r, 8'h11);
    rd(2'd1, r); chk("R7 second flags", r, stat(1, 0, 0, 0, 0));
    rd(2'd0, r); chk("R7 second kept", r, 8'h22);
    rd(2'd1, r); chk("R7 third lost", r, 8'h00);

    send(9'h066, 8, 2'b00, 0, 1);
    send(9'h077, 8, 2'b00, 0, 0);
    rd(2'd1, r); chk("R10 frame error", r, stat(1, 1, 0, 0, 0));
    wr(2'd2, 8'h00);
    rd(2'd1, r); chk("R2 flushed", r, 8'h00);
    chk("R3 released", rx_owned, 0);
    wr(2'd2, 8'h02);
    rd(2'd1, r); chk("R2 stays empty", r, 8'h00);

    @(negedge clk);
    bitout(0, 12);
    bitout(1, 200);
    rd(2'd1, r); chk("R9 glitch rejected", r, 8'h00);
    send(9'h05A, 8, 2'b00, 0, 0);
    rd(2'd0, r); chk("R9 frame after glitch", r, 8'h5A);

    cfg(8, 2'b10, 0);
    send(9'h0B7, 8, 2'b10, 1, 0);
    rd(2'd1, r); chk("R11 even bad", r, stat(1, 0, 0, 1, 0));
    rd(2'd0, r);
    cfg(7, 2'b11, 0);
    send(9'h05B, 7, 2'b11, 0, 0);
    rd(2'd1, r); chk("R11 odd good", r, stat(1, 0, 0, 0, 0));
    rd(2'd0, r); chk("R4 7-bit data", r, 8'h5B);

    for (int k = 0; k < 40; k++) begin
      int nb;
      logic [1:0] pm;
      logic [8:0] d;
      logic bp, bs, ie;
      nb = 5 + int'($urandom % 5);
      pm = ($urandom % 3 == 0) ? 2'b00 : {1'b1, 1'($urandom)};
      d = 9'($urandom);
      bp = pm[1] && ($urandom % 6 == 0);
      bs = ($urandom % 8 == 0);
      ie = 1'($urandom);
      gie = 1'($urandom);
      cfg(nb, pm, ie);
      send(d, nb, pm, bp, bs);
      rd(2'd1, r);
      chk($sformatf("R10 R11 R5 rand %0d status", k), r,
          stat(1, bs, 0, bp, nb == 9 ? d[8] : 1'b0));
      chk($sformatf("R1 rand %0d irq", k), irq, ie & gie);
      rd(2'd0, r);
      chk($sformatf("R4 rand %0d data", k), r, mask(d, nb) & 9'h0FF);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule